// File: doc/BRIEF.md
# Maskable Modem Status Change Detector

This block watches the four modem control inputs of a serial port (clear-to-send, data-set-ready, ring indicator and carrier detect) and the serial receive line. It reports their changes on three outputs: a modem-status interrupt request, an active-low power-management event and a wake pulse for an auto-sleep controller. All five inputs are asynchronous. Each one passes through a synchronizer. A copy of its previous synchronized value is held so that changes can be found.

A six-bit mask register, reached through a simple write/read port, has one disable bit per source. That one bit stops the source from raising the interrupt, the power-management event and the wake pulse. The register clears on reset, so every source is enabled by default. Clear-to-send, data-set-ready and carrier-detect report a change in either direction. The ring indicator reports only its trailing edge, where it goes inactive. The serial line can only drive the power-management event, and its change counts only while the power state is D2.

Top module: `msc_detect`

## Requirements
- R1: While reset is held and on the cycle after it, the mask reads 0x00, `irq_o` is 0, `pme_n_o` is 1 and `wake_o` is 0.
- R2: A write stores bits 5:0 of `mask_wdata_i`. `mask_rdata_o` returns them, with bits 7:6 always read as zero. Mask bit 0 disables CTS, bit 1 DSR, bit 2 RI, bit 3 DCD and bit 5 the serial line.
- R3: A change in either direction on CTS, DSR or DCD whose mask bit is clear is an event. An input change set up before rising edge k shows on the outputs just after edge k+2.
- R4: For RI only a 1-to-0 transition is an event; a 0-to-1 transition produces nothing.
- R5: An event sets a per-source pending flag, and `irq_o` equals the OR of the pending flags ANDed with `msi_en_i`. The flags survive while the enable is low. `int_clr_i` clears them at the next edge, and a simultaneous new event wins.
- R6: A modem source whose mask bit is set raises no interrupt, no power-management event and no wake.
- R7: When `pwr_state` equals the D2 code (2), a modem event drives `pme_n_o` low. In any other power state a modem event leaves `pme_n_o` high.
- R8: `pme_n_o` stays low until a rising edge at which `pwr_state` is not D2, or at which `pme_clr_i` is high with no new event. After that edge it reads 1.
- R9: A change on `sin_i` in either direction with mask bit 5 clear drives `pme_n_o` low in D2. With bit 5 set it does not. The serial line never raises `irq_o` or `wake_o`.
- R10: A modem event while `asleep_i` is high gives a `wake_o` pulse one cycle long. With `asleep_i` low, `wake_o` stays 0.
- R11: Mask bit 4 is reserved and stored, but has no effect on any source.
- R12: The input levels present when reset is released are not counted as changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_i | input | 1 | Clear-to-send, asynchronous, 1 = asserted |
| dsr_i | input | 1 | Data-set-ready, asynchronous, 1 = asserted |
| ri_i | input | 1 | Ring indicator, asynchronous, 1 = asserted |
| dcd_i | input | 1 | Carrier detect, asynchronous, 1 = asserted |
| sin_i | input | 1 | Serial receive line, asynchronous |
| pwr_state | input | PWR_W | Current power state, D2 encoded as PWR_D2 |
| asleep_i | input | 1 | UART is asleep under auto-sleep |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| int_clr_i | input | 1 | Clears the pending modem flags |
| pme_clr_i | input | 1 | Clears the power-management event |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| mask_rdata_o | output | 8 | Mask read data |
| irq_o | output | 1 | Modem-status interrupt request |
| pme_n_o | output | 1 | Power-management event, active low |
| wake_o | output | 1 | Wake pulse for the auto-sleep controller |

## Verification
An input change driven between edges reaches the event outputs just after the third rising edge that follows. The bench therefore drives stimulus on a falling edge and samples three falling edges later. It looks once more one cycle after that to confirm that the wake pulse is gone. `irq_o` follows `msi_en_i` without a register, so it is checked one nanosecond after the enable moves. Mask writes, the clear strobes and a change of power state act at the next rising edge, so those results are sampled at the falling edge that follows. The sweep runs through every source, every mask nibble, both edge directions and every combination of enable, sleep and power state. It works out each expected value from the requirement formulas.

// File: rtl/msc_pkg.sv
package msc_pkg;

    localparam int NSRC   = 4;
    localparam int MASK_W = 8;

    typedef enum logic [1:0] {
        SRC_CTS = 2'd0,
        SRC_DSR = 2'd1,
        SRC_RI  = 2'd2,
        SRC_DCD = 2'd3
    } msc_src_e;

    // level of every watched pin, modem lines indexed by msc_src_e
    typedef struct packed {
        logic [NSRC-1:0] lvl;
        logic            sin;
    } msc_pins_t;

    // qualified, unmasked events for one cycle
    typedef struct packed {
        logic [NSRC-1:0] modem;
        logic            sin;
    } msc_evt_t;

    // mask register layout
    typedef struct packed {
        logic [1:0]      rsvd_hi;
        logic            sin_off;
        logic            rsvd4;
        logic [NSRC-1:0] modem_off;
    } msc_mask_t;

    localparam int PINS_W = $bits(msc_pins_t);

    // sources reporting only the falling (inactive-going) edge
    function automatic bit src_is_trailing(input int idx);
        return idx == int'(SRC_RI);
    endfunction

endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] prv,
    output logic         ready
);
    localparam int VW = STAGES + 1;

    logic [W-1:0]  stg [STAGES];
    logic [VW-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            prv <= '0;
            vld <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            prv <= stg[STAGES-1];
            vld <= {vld[VW-2:0], 1'b1};
        end
    end

    assign q     = stg[STAGES-1];
    assign ready = vld[VW-1];

endmodule

// File: rtl/msc_mask_reg.sv
module msc_mask_reg
    import msc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [MASK_W-1:0] wdata,
    output msc_mask_t         mask,
    output logic [MASK_W-1:0] rdata
);
    logic [MASK_W-3:0] held;
    logic              unused_hi_bits;

    always_ff @(posedge clk) begin
        if (rst)     held <= '0;
        else if (we) held <= wdata[MASK_W-3:0];
    end

    assign unused_hi_bits = ^wdata[MASK_W-1:MASK_W-2];
    assign mask  = msc_mask_t'({2'b00, held});
    assign rdata = mask;

endmodule

// File: rtl/msc_event.sv
module msc_event
    import msc_pkg::*;
(
    input  msc_pins_t       cur,
    input  msc_pins_t       prv,
    input  logic            ready,
    input  logic [NSRC-1:0] modem_off,
    input  logic            sin_off,
    output msc_evt_t        evt
);
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (src_is_trailing(g)) begin : g_trail
            assign raw[g] = prv.lvl[g] & ~cur.lvl[g];
        end else begin : g_delta
            assign raw[g] = prv.lvl[g] ^ cur.lvl[g];
        end
        assign hit[g] = ready & raw[g] & ~modem_off[g];
    end

    assign evt.modem = hit;
    assign evt.sin   = ready & (prv.sin ^ cur.sin) & ~sin_off;

endmodule

// File: rtl/msc_out.sv
module msc_out
    import msc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  msc_evt_t evt,
    input  logic     in_d2,
    input  logic     asleep,
    input  logic     int_en,
    input  logic     int_clr,
    input  logic     pme_clr,
    output logic     irq,
    output logic     pme_n,
    output logic     wake
);
    logic [NSRC-1:0] pend;
    logic            pme_act;
    logic            wake_q;
    logic            any_modem;

    assign any_modem = |evt.modem;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            pme_act <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            pend <= (int_clr ? '0 : pend) | evt.modem;
            if (!in_d2)                     pme_act <= 1'b0;
            else if (any_modem || evt.sin)  pme_act <= 1'b1;
            else if (pme_clr)               pme_act <= 1'b0;
            wake_q <= asleep & any_modem;
        end
    end

    assign irq   = int_en & (|pend);
    assign pme_n = ~pme_act;
    assign wake  = wake_q;

endmodule

// File: rtl/msc_detect.sv
module msc_detect
    import msc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PWR_W       = 2,
    parameter int PWR_D2      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_i,
    input  logic              dsr_i,
    input  logic              ri_i,
    input  logic              dcd_i,
    input  logic              sin_i,
    input  logic [PWR_W-1:0]  pwr_state,
    input  logic              asleep_i,
    input  logic              msi_en_i,
    input  logic              int_clr_i,
    input  logic              pme_clr_i,
    input  logic              mask_we_i,
    input  logic [MASK_W-1:0] mask_wdata_i,
    output logic [MASK_W-1:0] mask_rdata_o,
    output logic              irq_o,
    output logic              pme_n_o,
    output logic              wake_o
);
    msc_pins_t raw_pins;
    msc_pins_t cur_pins;
    msc_pins_t prv_pins;
    logic      pins_ready;
    msc_mask_t mask;
    msc_evt_t  evt;
    logic      in_d2;

    assign raw_pins.lvl = {dcd_i, ri_i, dsr_i, cts_i};
    assign raw_pins.sin = sin_i;
    assign in_d2 = (pwr_state == PWR_W'(PWR_D2));

    msc_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d     (raw_pins),
        .q     (cur_pins),
        .prv   (prv_pins),
        .ready (pins_ready)
    );

    msc_mask_reg u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (mask_we_i),
        .wdata (mask_wdata_i),
        .mask  (mask),
        .rdata (mask_rdata_o)
    );

    msc_event u_evt (
        .cur       (cur_pins),
        .prv       (prv_pins),
        .ready     (pins_ready),
        .modem_off (mask.modem_off),
        .sin_off   (mask.sin_off),
        .evt       (evt)
    );

    msc_out u_out (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .in_d2   (in_d2),
        .asleep  (asleep_i),
        .int_en  (msi_en_i),
        .int_clr (int_clr_i),
        .pme_clr (pme_clr_i),
        .irq     (irq_o),
        .pme_n   (pme_n_o),
        .wake    (wake_o)
    );

endmodule

// File: rtl/msc_detect_chk.sv
module msc_detect_chk #(
    parameter int PWR_W  = 2,
    parameter int PWR_D2 = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [PWR_W-1:0] pwr_state,
    input logic             asleep_i,
    input logic             msi_en_i,
    input logic [7:0]       mask_rdata_o,
    input logic             irq_o,
    input logic             pme_n_o,
    input logic             wake_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq_o && pme_n_o && !wake_o && mask_rdata_o == 8'h00));

    // R2
    rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
        mask_rdata_o[7:6] == 2'b00);

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !msi_en_i |-> !irq_o);

    // R7
    pme_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pme_n_o) |-> ($past(pwr_state) == PWR_W'(PWR_D2)));

    // R8
    pme_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != PWR_W'(PWR_D2)) |=> pme_n_o);

    // R10
    wake_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(asleep_i));

endmodule

bind msc_detect msc_detect_chk #(.PWR_W(PWR_W), .PWR_D2(PWR_D2)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pwr_state    (pwr_state),
    .asleep_i     (asleep_i),
    .msi_en_i     (msi_en_i),
    .mask_rdata_o (mask_rdata_o),
    .irq_o        (irq_o),
    .pme_n_o      (pme_n_o),
    .wake_o       (wake_o)
);

// File: tb/sim_msc_detect.sv
`timescale 1ns/1ps
module sim_msc_detect;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] mdm;
    logic       sin;
    logic [1:0] pwr;
    logic       asleep, msi_en, int_clr, pme_clr, we;
    logic [7:0] wdata, rdata;
    logic       irq, pme_n, wake;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    msc_detect u0 (
        .clk(clk), .rst(rst),
        .cts_i(mdm[0]), .dsr_i(mdm[1]), .ri_i(mdm[2]), .dcd_i(mdm[3]),
        .sin_i(sin), .pwr_state(pwr), .asleep_i(asleep), .msi_en_i(msi_en),
        .int_clr_i(int_clr), .pme_clr_i(pme_clr), .mask_we_i(we),
        .mask_wdata_i(wdata), .mask_rdata_o(rdata),
        .irq_o(irq), .pme_n_o(pme_n), .wake_o(wake)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [7:0] v);
        we = 1'b1; wdata = v;
        tick(1);
        we = 1'b0;
    endtask

    task automatic clear_all();
        int_clr = 1'b1; pme_clr = 1'b1;
        tick(1);
        int_clr = 1'b0; pme_clr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; mdm = 4'b1111; sin = 1'b1; pwr = 2'd2;
        asleep = 1'b1; msi_en = 1'b1; int_clr = 1'b0; pme_clr = 1'b0;
        we = 1'b0; wdata = 8'h00;
        tick(3);
        chk("R1 mask", rdata, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 pme_n", pme_n, 1);
        chk("R1 wake", wake, 0);
        rst = 1'b0;
        // R12: high levels at release are not changes
        tick(8);
        chk("R12 irq", irq, 0);
        chk("R12 pme_n", pme_n, 1);
        chk("R12 wake", wake, 0);

        // R2 readback
        wr_mask(8'hFF); chk("R2 ff", rdata, 8'h3F);
        wr_mask(8'hC0); chk("R2 c0", rdata, 8'h00);
        wr_mask(8'h15); chk("R2 15", rdata, 8'h15);

        // sweep: source, mask nibble, direction, enable/sleep/power
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 16; m++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    for (int cfg = 0; cfg < 8; cfg++) begin : one
                        logic st, ie, sl, d2, ev, hit, b4;
                        string tg;
                        st = (dir == 1);
                        ie = cfg[0]; sl = cfg[1]; d2 = cfg[2];
                        b4 = cfg[0] ^ m[0];
                        wr_mask(8'h2F);
                        mdm[s] = st;
                        tick(4);
                        clear_all();
                        msi_en = ie; asleep = sl; pwr = d2 ? 2'd2 : 2'd1;
                        wr_mask({2'b00, 1'b1, b4, 4'(m)});
                        mdm[s] = ~st;
                        tick(3);
                        ev  = (s != 2) || (dir == 1);
                        hit = ev && !m[s];
                        if (m[s]) tg = "R6";
                        else if (s == 2) tg = "R4";
                        else tg = "R3";
                        if (b4) tg = {tg, " R11"};
                        chk({tg, " irq"}, irq, 32'(hit & ie));
                        chk({tg, " R7 pme_n"}, pme_n, 32'(!(hit & d2)));
                        chk({tg, " R10 wake"}, wake, 32'(hit & sl));
                        tick(1);
                        chk("R10 wake pulse end", wake, 0);
                        msi_en = 1'b1;
                        #1;
                        chk("R5 pending kept", irq, 32'(hit));
                        tick(1);
                        int_clr = 1'b1;
                        tick(1);
                        int_clr = 1'b0;
                        chk("R5 clear", irq, 0);
                    end
                end
            end
        end

        // R9: serial line
        for (int d2 = 0; d2 < 2; d2++) begin
            for (int b5 = 0; b5 < 2; b5++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    wr_mask(8'h2F);
                    sin = (dir == 1);
                    tick(4);
                    clear_all();
                    msi_en = 1'b1; asleep = 1'b1; pwr = (d2 == 1) ? 2'd2 : 2'd0;
                    wr_mask({2'b00, 1'(b5), 5'b00000});
                    sin = ~sin;
                    tick(3);
                    chk("R9 pme_n", pme_n, 32'(!((d2 == 1) && (b5 == 0))));
                    chk("R9 irq", irq, 0);
                    chk("R9 wake", wake, 0);
                end
            end
        end

        // R8: hold and release
        wr_mask(8'h00); pwr = 2'd2; asleep = 1'b0;
        clear_all();
        mdm[0] = ~mdm[0];
        tick(3);
        chk("R7 pme low", pme_n, 0);
        tick(10);
        chk("R8 held", pme_n, 0);
        pme_clr = 1'b1; tick(1); pme_clr = 1'b0;
        chk("R8 strobe release", pme_n, 1);
        mdm[1] = ~mdm[1];
        tick(3);
        chk("R8 low again", pme_n, 0);
        pwr = 2'd3;
        tick(1);
        chk("R8 leave D2", pme_n, 1);
        chk("R10 awake no wake", wake, 0);

        // R11 alone
        pwr = 2'd2; clear_all();
        wr_mask(8'h10);
        mdm[3] = ~mdm[3];
        tick(3);
        chk("R11 irq", irq, 1);
        chk("R11 pme_n", pme_n, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule